// File: doc/BRIEF.md
# External Bus Strobe and Select Controller

This block drives the external memory control pins of a small microcontroller with 16 KB of on-chip code storage. It runs from the oscillator clock and divides it into machine cycles of twelve phases. From the program counter, the data address and a data-move indication supplied by the CPU, it generates the address latch enable, the code read strobe, the external memory select, the data read and write strobes, and the values driven on the two address-capable ports.

Whether code comes from on-chip or external storage depends on an external-access pin and on the program counter. The pin is captured while reset is held and is frozen once reset is released. A reserved window at the top of the lower 32 KB of data space is kept off the external bus by masking the strobes. Idle and power-down states force the control pins to fixed levels. A general-purpose mode lets the select pin carry a plain output bit.

Top module: `xbus_ctrl`

## Requirements
- R1: `ea_pin` is captured on every clock edge while `rst` is high. Once `rst` is low, later changes of `ea_pin` have no effect on any output.
- R2: A non-data cycle fetches externally when the captured pin is 0 or `pc_i` is above 16'h3FFF, and internally otherwise. During an external fetch `psen_n_o` is low in phases 3, 4, 9 and 10. It stays high for internal fetches and for data cycles.
- R3: In the running state `memcs_n_o` is low for the whole cycle when the captured pin is 0 or `pc_i` is 16'h4000 or more. Otherwise it is high.
- R4: Phase 0 is the first output cycle after a cycle boundary. In a non-data running cycle `ale_o` is high in phases 0, 1, 6 and 7 and low in all other phases. `pc_i`, `daddr_i`, `movx_i` and `movx_wr_i` are captured at each cycle boundary.
- R5: A data cycle is one with `movx_i`=1. In a data cycle the `ale_o` pulse in phases 6 and 7 is skipped. The bus address is `daddr_i`, and the selected strobe (`movx_wr_i`=0 read, 1 write) is low in phases 3 through 10. The two strobes are never low together.
- R6: `wr_n_o` stays high for data addresses 16'h7FF0 through 16'h7FFF.
- R7: `rd_n_o` stays high for data addresses 16'h7FF0 through 16'hFFFF.
- R8: With `cfg_ale_off`=1 in the running state, `ale_o` stays low and no other output changes.
- R9: With `idle_i`=1 and `pdown_i`=0, `ale_o` and `psen_n_o` are high, both strobes are high, and both ports hold their last values.
- R10: With `pdown_i`=1 (taking priority over idle), `ale_o` and `psen_n_o` are low, both strobes are high, and the ports hold. `memcs_n_o` is high in idle and power-down unless `cfg_cs_gpio`=1.
- R11: `p1_o` carries bits 7:0 of the bus address when `low_addr_en`=1, and `p1_latch` otherwise.
- R12: `p2_o[6:0]` carries bus address bits 14:8 and `p2_o[7]` carries `p2_latch[7]` when the captured pin is 0 or `cfg_p2_addr`=1. Otherwise `p2_o` equals `p2_latch`.
- R13: While `rst` is high, outputs reset to `ale_o`=0, all active-low controls=1, and both ports=8'hFF. With `cfg_cs_gpio`=1, `memcs_n_o` follows `cs_gpio_val` in every non-reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_pin | input | 1 | External-access pin, captured during reset |
| low_addr_en | input | 1 | Port 1 emits low address byte when high |
| pc_i | input | 16 | Program counter |
| daddr_i | input | 16 | Data-move address |
| movx_i | input | 1 | Next machine cycle is a data cycle |
| movx_wr_i | input | 1 | Data cycle direction, 1 = write |
| idle_i | input | 1 | Idle state |
| pdown_i | input | 1 | Power-down state |
| cfg_ale_off | input | 1 | Suppress address latch enable |
| cfg_cs_gpio | input | 1 | Select pin used as plain output |
| cfg_p2_addr | input | 1 | Port 2 address output with internal code |
| cs_gpio_val | input | 1 | Select pin value in plain-output mode |
| p1_latch | input | 8 | Port 1 latch contents |
| p2_latch | input | 8 | Port 2 latch contents |
| ale_o | output | 1 | Address latch enable |
| psen_n_o | output | 1 | External code read strobe, active low |
| memcs_n_o | output | 1 | External memory select, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p1_o | output | 8 | Port 1 pin value |
| p2_o | output | 8 | Port 2 pin value |

## Verification
The bench goes after the fetch boundary at 16'h3FFF/16'h4000. A design that compared against the wrong limit would either drop the code read strobe on the last on-chip byte or fetch the first external byte internally. It drives data addresses at both edges of the reserved window (16'h7FEF, 16'h7FF0, 16'h7FFF, 16'h8000, 16'hFFFF). A design that shared one range between the two strobes would either let a write through at 16'h8000 be blocked or leak a read above 16'h7FFF. It flips the external-access pin after reset, which catches a design that samples the pin live. It also checks that power-down overrides idle, and that ports hold through low-power states instead of tracking the address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_ADDR_W = 16;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

  typedef struct packed {
    logic                 is_data;
    logic                 is_wr;
    logic [XB_ADDR_W-1:0] pc;
    logic [XB_ADDR_W-1:0] daddr;
  } bus_cycle_t;
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
#(
  parameter int CYC_LEN = 12,
  localparam int PH_W = $clog2(CYC_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [XB_ADDR_W-1:0] pc_i,
  input  logic [XB_ADDR_W-1:0] daddr_i,
  input  logic                 movx_i,
  input  logic                 movx_wr_i,
  output logic [PH_W-1:0]      ph_nxt,
  output bus_cycle_t           cyc_nxt,
  output bus_cycle_t           cyc_q
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] ph_q;

  always_comb begin
    ph_nxt  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    cyc_nxt = cyc_q;
    if (ph_q == PH_LAST) begin
      cyc_nxt.is_data = movx_i;
      cyc_nxt.is_wr   = movx_wr_i;
      cyc_nxt.pc      = pc_i;
      cyc_nxt.daddr   = daddr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_LAST;
      cyc_q <= '0;
    end else begin
      ph_q  <= ph_nxt;
      cyc_q <= cyc_nxt;
    end
  end

  // R4
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_LAST) |=> (ph_q == '0));
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter logic [XB_ADDR_W-1:0] INT_TOP   = 16'h3FFF,
  parameter logic [XB_ADDR_W-1:0] RSV_LO    = 16'h7FF0,
  parameter logic [XB_ADDR_W-1:0] RSV_WR_HI = 16'h7FFF
) (
  input  logic                 ea_lat,
  input  bus_cycle_t           cyc,
  output logic                 ext_code,
  output logic                 rd_ok,
  output logic                 wr_ok,
  output logic [XB_ADDR_W-1:0] bus_addr
);
  logic in_rsv_rd;
  logic in_rsv_wr;

  always_comb begin
    ext_code  = !ea_lat || (cyc.pc > INT_TOP);
    in_rsv_rd = (cyc.daddr >= RSV_LO);
    in_rsv_wr = (cyc.daddr >= RSV_LO) && (cyc.daddr <= RSV_WR_HI);
    rd_ok     = cyc.is_data && !cyc.is_wr && !in_rsv_rd;
    wr_ok     = cyc.is_data &&  cyc.is_wr && !in_rsv_wr;
    bus_addr  = cyc.is_data ? cyc.daddr : cyc.pc;
  end
endmodule

// File: rtl/xbus_portmux.sv
module xbus_portmux
  import xbus_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int HI_W = XB_ADDR_W - 1 - PORT_W
) (
  input  logic [XB_ADDR_W-1:0] bus_addr,
  input  logic                 low_addr_en,
  input  logic                 hi_addr_en,
  input  logic [PORT_W-1:0]    p1_latch,
  input  logic [PORT_W-1:0]    p2_latch,
  output logic [PORT_W-1:0]    p1_nxt,
  output logic [PORT_W-1:0]    p2_nxt
);
  wire unused_top = bus_addr[XB_ADDR_W-1];

  always_comb begin
    p1_nxt = low_addr_en ? bus_addr[PORT_W-1:0] : p1_latch;
    if (hi_addr_en)
      p2_nxt = {p2_latch[PORT_W-1:HI_W], bus_addr[XB_ADDR_W-2:PORT_W]};
    else
      p2_nxt = p2_latch;
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int PORT_W  = 8,
  parameter logic [XB_ADDR_W-1:0] INT_TOP   = 16'h3FFF,
  parameter logic [XB_ADDR_W-1:0] RSV_LO    = 16'h7FF0,
  parameter logic [XB_ADDR_W-1:0] RSV_WR_HI = 16'h7FFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ea_pin,
  input  logic                 low_addr_en,
  input  logic [XB_ADDR_W-1:0] pc_i,
  input  logic [XB_ADDR_W-1:0] daddr_i,
  input  logic                 movx_i,
  input  logic                 movx_wr_i,
  input  logic                 idle_i,
  input  logic                 pdown_i,
  input  logic                 cfg_ale_off,
  input  logic                 cfg_cs_gpio,
  input  logic                 cfg_p2_addr,
  input  logic                 cs_gpio_val,
  input  logic [PORT_W-1:0]    p1_latch,
  input  logic [PORT_W-1:0]    p2_latch,
  output logic                 ale_o,
  output logic                 psen_n_o,
  output logic                 memcs_n_o,
  output logic                 rd_n_o,
  output logic                 wr_n_o,
  output logic [PORT_W-1:0]    p1_o,
  output logic [PORT_W-1:0]    p2_o
);
  localparam int PH_W = $clog2(CYC_LEN);
  localparam int HALF = CYC_LEN / 2;
  localparam logic [PH_W-1:0] HALF_P   = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_END  = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] CODE_LO  = PH_W'(ALE_W + 1);
  localparam logic [PH_W-1:0] CODE_HI  = PH_W'(HALF - 2);
  localparam logic [PH_W-1:0] STRB_LO  = PH_W'(ALE_W + 1);
  localparam logic [PH_W-1:0] STRB_HI  = PH_W'(CYC_LEN - 2);

  logic [PH_W-1:0]      ph_nxt;
  bus_cycle_t           cyc_nxt;
  bus_cycle_t           cyc_q;
  logic                 ea_lat;
  logic                 ext_code;
  logic                 rd_ok;
  logic                 wr_ok;
  logic [XB_ADDR_W-1:0] bus_addr;
  logic [PORT_W-1:0]    p1_nxt;
  logic [PORT_W-1:0]    p2_nxt;

  xbus_phase #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .pc_i      (pc_i),
    .daddr_i   (daddr_i),
    .movx_i    (movx_i),
    .movx_wr_i (movx_wr_i),
    .ph_nxt    (ph_nxt),
    .cyc_nxt   (cyc_nxt),
    .cyc_q     (cyc_q)
  );

  xbus_decode #(
    .INT_TOP   (INT_TOP),
    .RSV_LO    (RSV_LO),
    .RSV_WR_HI (RSV_WR_HI)
  ) u_decode (
    .ea_lat   (ea_lat),
    .cyc      (cyc_nxt),
    .ext_code (ext_code),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .bus_addr (bus_addr)
  );

  xbus_portmux #(.PORT_W(PORT_W)) u_portmux (
    .bus_addr    (bus_addr),
    .low_addr_en (low_addr_en),
    .hi_addr_en  (!ea_lat || cfg_p2_addr),
    .p1_latch    (p1_latch),
    .p2_latch    (p2_latch),
    .p1_nxt      (p1_nxt),
    .p2_nxt      (p2_nxt)
  );

  // External-access pin is only captured while reset is held.
  always_ff @(posedge clk) begin
    if (rst) ea_lat <= ea_pin;
  end

  pwr_mode_e        mode;
  logic             in_hi;
  logic [PH_W-1:0]  off;
  logic             ale_slot;
  logic             code_slot;
  logic             strb_slot;
  logic             ale_d, psen_n_d, memcs_n_d, rd_n_d, wr_n_d;
  logic [PORT_W-1:0] p1_d, p2_d;

  always_comb begin
    if (pdown_i)     mode = MODE_PDOWN;
    else if (idle_i) mode = MODE_IDLE;
    else             mode = MODE_RUN;

    in_hi     = (ph_nxt >= HALF_P);
    off       = in_hi ? (ph_nxt - HALF_P) : ph_nxt;
    ale_slot  = (off < ALE_END);
    code_slot = (off >= CODE_LO) && (off <= CODE_HI);
    strb_slot = (ph_nxt >= STRB_LO) && (ph_nxt <= STRB_HI);

    ale_d     = 1'b0;
    psen_n_d  = 1'b1;
    memcs_n_d = 1'b1;
    rd_n_d    = 1'b1;
    wr_n_d    = 1'b1;
    p1_d      = p1_o;
    p2_d      = p2_o;

    unique case (mode)
      MODE_RUN: begin
        ale_d     = ale_slot && !(cyc_nxt.is_data && in_hi) && !cfg_ale_off;
        psen_n_d  = !(code_slot && ext_code && !cyc_nxt.is_data);
        memcs_n_d = !ext_code;
        rd_n_d    = !(rd_ok && strb_slot);
        wr_n_d    = !(wr_ok && strb_slot);
        p1_d      = p1_nxt;
        p2_d      = p2_nxt;
      end
      MODE_IDLE: begin
        ale_d    = 1'b1;
        psen_n_d = 1'b1;
      end
      default: begin
        ale_d    = 1'b0;
        psen_n_d = 1'b0;
      end
    endcase

    if (cfg_cs_gpio) memcs_n_d = cs_gpio_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o     <= 1'b0;
      psen_n_o  <= 1'b1;
      memcs_n_o <= 1'b1;
      rd_n_o    <= 1'b1;
      wr_n_o    <= 1'b1;
      p1_o      <= '1;
      p2_o      <= '1;
    end else begin
      ale_o     <= ale_d;
      psen_n_o  <= psen_n_d;
      memcs_n_o <= memcs_n_d;
      rd_n_o    <= rd_n_d;
      wr_n_o    <= wr_n_d;
      p1_o      <= p1_d;
      p2_o      <= p2_d;
    end
  end

  // R1
  ea_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ea_lat));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o));

  // R6
  wr_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> !((cyc_q.daddr >= RSV_LO) && (cyc_q.daddr <= RSV_WR_HI)));

  // R7
  rd_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> (cyc_q.daddr < RSV_LO));

  // R9
  idle_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !pdown_i) |=> (ale_o && psen_n_o && rd_n_o && wr_n_o));

  // R10
  pdown_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    pdown_i |=> (!ale_o && !psen_n_o && rd_n_o && wr_n_o));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ea_pin = 1'b1;
  logic        low_addr_en = 1'b1;
  logic [15:0] pc_i = '0;
  logic [15:0] daddr_i = '0;
  logic        movx_i = 1'b0;
  logic        movx_wr_i = 1'b0;
  logic        idle_i = 1'b0;
  logic        pdown_i = 1'b0;
  logic        cfg_ale_off = 1'b0;
  logic        cfg_cs_gpio = 1'b0;
  logic        cfg_p2_addr = 1'b0;
  logic        cs_gpio_val = 1'b0;
  logic [7:0]  p1_latch = 8'h5A;
  logic [7:0]  p2_latch = 8'hC3;
  logic        ale_o, psen_n_o, memcs_n_o, rd_n_o, wr_n_o;
  logic [7:0]  p1_o, p2_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic       b_ea;
  logic [7:0] b_p1 = 8'hFF;
  logic [7:0] b_p2 = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst(rst), .ea_pin(ea_pin), .low_addr_en(low_addr_en),
    .pc_i(pc_i), .daddr_i(daddr_i), .movx_i(movx_i), .movx_wr_i(movx_wr_i),
    .idle_i(idle_i), .pdown_i(pdown_i), .cfg_ale_off(cfg_ale_off),
    .cfg_cs_gpio(cfg_cs_gpio), .cfg_p2_addr(cfg_p2_addr),
    .cs_gpio_val(cs_gpio_val), .p1_latch(p1_latch), .p2_latch(p2_latch),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .memcs_n_o(memcs_n_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .p1_o(p1_o), .p2_o(p2_o)
  );

  task automatic compare(input string req, input int ph, input logic [20:0] exp);
    logic [20:0] got;
    got = {ale_o, psen_n_o, memcs_n_o, rd_n_o, wr_n_o, p1_o, p2_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s phase %0d: got ale/psen/cs/rd/wr/p1/p2=%b%b%b%b%b/%h/%h expected %b%b%b%b%b/%h/%h",
               req, ph, got[20], got[19], got[18], got[17], got[16], got[15:8], got[7:0],
               exp[20], exp[19], exp[18], exp[17], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  // One machine cycle: 12 edges, each phase checked against the bench model.
  task automatic run_cycle(input string req);
    for (int p = 0; p < 12; p++) begin
      logic e_ale, e_psen, e_cs, e_rd, e_wr, ext, strb;
      logic [15:0] addr;
      @(posedge clk); #1;
      ext  = !b_ea || (pc_i >= 16'h4000);
      strb = (p >= 3) && (p <= 10);
      addr = movx_i ? daddr_i : pc_i;
      e_rd = 1'b1; e_wr = 1'b1; e_cs = 1'b1;
      if (pdown_i) begin
        e_ale = 1'b0; e_psen = 1'b0;
      end else if (idle_i) begin
        e_ale = 1'b1; e_psen = 1'b1;
      end else begin
        e_ale  = ((p == 0) || (p == 1) || (!movx_i && ((p == 6) || (p == 7)))) && !cfg_ale_off;
        e_psen = !(!movx_i && ext && ((p == 3) || (p == 4) || (p == 9) || (p == 10)));
        e_cs   = !ext;
        e_rd   = !(movx_i && !movx_wr_i && strb && (daddr_i < 16'h7FF0));
        e_wr   = !(movx_i && movx_wr_i && strb && !((daddr_i >= 16'h7FF0) && (daddr_i <= 16'h7FFF)));
        b_p1   = low_addr_en ? addr[7:0] : p1_latch;
        b_p2   = (!b_ea || cfg_p2_addr) ? {p2_latch[7], addr[14:8]} : p2_latch;
      end
      if (cfg_cs_gpio) e_cs = cs_gpio_val;
      compare(req, p, {e_ale, e_psen, e_cs, e_rd, e_wr, b_p1, b_p2});
    end
  endtask

  task automatic do_reset(input logic ea);
    rst = 1'b1;
    ea_pin = ea;
    repeat (3) @(posedge clk);
    #1;
    b_p1 = 8'hFF; b_p2 = 8'hFF;
    compare("R13", -1, {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF});
    b_ea = ea;
    rst = 1'b0;
    ea_pin = !ea; // R1: must be ignored from now on
  endtask

  task automatic t_ea_latch();
    do_reset(1'b1);
    pc_i = 16'h0100; movx_i = 1'b0;
    run_cycle("R1");
  endtask

  task automatic t_fetch_boundary();
    pc_i = 16'h3FFF; run_cycle("R2");
    pc_i = 16'h4000; run_cycle("R3");
    pc_i = 16'hFFFE; run_cycle("R4");
  endtask

  task automatic t_data_cycles();
    pc_i = 16'h0200; movx_i = 1'b1;
    movx_wr_i = 1'b0; daddr_i = 16'h1234; run_cycle("R5");
    daddr_i = 16'h7FEF; run_cycle("R7");
    daddr_i = 16'h7FF0; run_cycle("R7");
    daddr_i = 16'hFFFF; run_cycle("R7");
    movx_wr_i = 1'b1; daddr_i = 16'h7FFF; run_cycle("R6");
    daddr_i = 16'h7FF0; run_cycle("R6");
    daddr_i = 16'h8000; run_cycle("R6");
    movx_i = 1'b0; movx_wr_i = 1'b0;
  endtask

  task automatic t_ale_off();
    cfg_ale_off = 1'b1; pc_i = 16'h4321; run_cycle("R8");
    cfg_ale_off = 1'b0;
  endtask

  task automatic t_ports();
    low_addr_en = 1'b0; pc_i = 16'h5678; run_cycle("R11");
    low_addr_en = 1'b1; cfg_p2_addr = 1'b1; pc_i = 16'h1ABC; run_cycle("R12");
    cfg_p2_addr = 1'b0; run_cycle("R12");
  endtask

  task automatic t_low_power();
    pc_i = 16'h6000; idle_i = 1'b1; run_cycle("R9");
    pdown_i = 1'b1; run_cycle("R10");
    idle_i = 1'b0; cfg_cs_gpio = 1'b1; cs_gpio_val = 1'b0; run_cycle("R10");
    cs_gpio_val = 1'b1; pdown_i = 1'b0; run_cycle("R13");
    cfg_cs_gpio = 1'b0; cs_gpio_val = 1'b0;
  endtask

  task automatic t_ext_only();
    do_reset(1'b0);
    pc_i = 16'h0010; run_cycle("R2");
    movx_i = 1'b1; movx_wr_i = 1'b1; daddr_i = 16'h2468; run_cycle("R12");
    movx_i = 1'b0; movx_wr_i = 1'b0;
  endtask

  initial begin
    t_ea_latch();
    t_fetch_boundary();
    t_data_cycles();
    t_ale_off();
    t_ports();
    t_low_power();
    t_ext_only();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule